// File: doc/BRIEF.md
# Dual-Line Fetch Collapser

The collapser sits between instruction fetch and rename. Each cycle it receives two groups of instruction slots, one per fetched cache line. The second line either follows the first in address order or is the target of a predicted-taken branch in the first line; the front end decides which. Every slot has a valid bit and a predicted-taken flag. The block keeps only the slots on the predicted path and packs them, in program order, into a single eight-wide output group. It also reports how many slots it emitted and where to resume when the predicted path held more than eight instructions.

The second line carries a start offset. Slots below that offset are never on the path, whether the line is sequential or a branch target. Each line is cut after its first predicted-taken valid slot, so at most two taken branches shape a group. The thread tag of the group passes through unchanged.

Input and output are both valid/ready streams with one registered stage between them:
- The input is accepted when the output register is empty or is being drained in the same cycle.
- While the consumer holds `out_ready` low, the registered group stays exactly as it is and new input is refused.
- The combinational selection and packing happen before the register, so a group appears on the output one cycle after acceptance.

Top module: `fc_collapser`

## Requirements
- R1: In line A (candidate slots 0..7), a valid slot survives only if no valid slot with a lower index is flagged predicted-taken. The first valid taken slot survives and every A slot after it is dropped. Invalid slots never survive.
- R2: In line B, every slot whose index is below `b_start` is dropped, whatever its valid or taken bits.
- R3: In line B, a valid slot at or above `b_start` survives only if no valid slot from `b_start` up to the slot below it is flagged taken. A taken flag below `b_start` does not cut the line.
- R4: Survivors are placed in program order (all of line A by ascending index, then line B by ascending index) into output positions 0 upward. `out_vld` is contiguous from bit 0, and `out_count` equals the number of set `out_vld` bits.
- R5: When more than 8 slots survive, the first 8 in program order are emitted and `out_trunc` is 1. `out_resume` then gives the line-B index of the first survivor that was not emitted. Otherwise `out_trunc` is 0 and `out_resume` is 0.
- R6: `out_tid` equals the `in_tid` of the accepted group. Each `out_taken` bit equals the taken flag of the candidate placed in that position, and is 0 in empty positions.
- R7: `in_ready` equals `!out_valid || out_ready`. A group accepted at a clock edge is presented on the output after that edge. While `out_valid` is high and `out_ready` is low, `out_valid` and every output field stay unchanged.
- R8: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input group offered |
| in_ready | output | 1 | Input group can be taken |
| a_insn | input | SLOTS*IW | Line A instruction words, slot 0 in the low bits |
| a_vld | input | SLOTS | Line A slot valid |
| a_taken | input | SLOTS | Line A slot predicted taken |
| b_insn | input | SLOTS*IW | Line B instruction words |
| b_vld | input | SLOTS | Line B slot valid |
| b_taken | input | SLOTS | Line B slot predicted taken |
| b_start | input | log2(SLOTS) | First line B slot on the path |
| in_tid | input | TIDW | Thread tag of the group |
| out_valid | output | 1 | Packed group present |
| out_ready | input | 1 | Consumer takes the packed group |
| out_insn | output | SLOTS*IW | Packed instruction words |
| out_vld | output | SLOTS | Packed slot valid, contiguous from 0 |
| out_taken | output | SLOTS | Taken flag of each packed slot |
| out_count | output | log2(SLOTS+1) | Number of packed slots |
| out_trunc | output | 1 | Path held more than SLOTS survivors |
| out_resume | output | log2(SLOTS) | Line B index of first unemitted survivor |
| out_tid | output | TIDW | Thread tag carried through |

## Verification
Some properties are checked on every cycle:
- the registered output stays frozen under back-pressure;
- the valid mask is contiguous and its population matches the count;
- a truncated group is always full;
- each line keeps at most one taken slot after cutting.

Which slots survive and the order they are packed in can only be judged against a reference computed from the inputs. The scenarios therefore cover:
- taken cuts at the edges of both lines;
- a start offset that hides a taken flag;
- holes in the valid masks;
- exactly eight and exactly nine survivors;
- random stall patterns on the output.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int unsigned FC_SLOTS = 8;
  localparam int unsigned FC_IW    = 32;
  localparam int unsigned FC_TIDW  = 2;

  // width needed to hold the values 0..n
  function automatic int unsigned fc_cnt_w(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/fc_path_mask.sv
// Marks the slots of one fetch line that lie on the predicted path.
module fc_path_mask
  import fc_pkg::*;
#(
  parameter int unsigned SLOTS = FC_SLOTS,
  localparam int unsigned IDXW = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] vld,
  input  logic [SLOTS-1:0] tk,
  input  logic [IDXW-1:0]  start,
  output logic [SLOTS-1:0] keep
);
  logic cut_seen;

  always_comb begin
    cut_seen = 1'b0;
    keep     = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && (IDXW'(i) >= start) && !cut_seen) begin
        keep[i] = 1'b1;
        if (tk[i]) cut_seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fc_pack.sv
// Compacts up to 2*SLOTS kept candidates into SLOTS output positions.
module fc_pack
  import fc_pkg::*;
#(
  parameter int unsigned SLOTS = FC_SLOTS,
  parameter int unsigned IW    = FC_IW,
  localparam int unsigned NC   = 2 * SLOTS,
  localparam int unsigned IDXW = $clog2(SLOTS),
  localparam int unsigned PW   = fc_cnt_w(NC),
  localparam int unsigned CNTW = fc_cnt_w(SLOTS)
) (
  input  logic [NC-1:0][IW-1:0]    cand_insn,
  input  logic [NC-1:0]            cand_tk,
  input  logic [NC-1:0]            keep,
  output logic [SLOTS-1:0][IW-1:0] o_insn,
  output logic [SLOTS-1:0]         o_vld,
  output logic [SLOTS-1:0]         o_tk,
  output logic [CNTW-1:0]          o_count,
  output logic                     o_trunc,
  output logic [IDXW-1:0]          o_resume
);
  logic [NC-1:0][PW-1:0] pos;
  logic [PW-1:0]         total;

  // running survivor count gives each candidate its output position
  always_comb begin
    logic [PW-1:0] run;
    run = '0;
    for (int k = 0; k < NC; k++) begin
      pos[k] = run;
      if (keep[k]) run = run + PW'(1);
    end
    total = run;
  end

  // one-hot select per output position
  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      o_insn[j] = '0;
      o_tk[j]   = 1'b0;
      for (int k = 0; k < NC; k++) begin
        if (keep[k] && (pos[k] == PW'(j))) begin
          o_insn[j] = o_insn[j] | cand_insn[k];
          o_tk[j]   = o_tk[j] | cand_tk[k];
        end
      end
    end
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_vld
    assign o_vld[j] = (total > PW'(j));
  end

  assign o_trunc = (total > PW'(SLOTS));
  assign o_count = o_trunc ? CNTW'(SLOTS) : CNTW'(total);

  // only line B survivors can overflow: line A alone holds at most SLOTS
  always_comb begin
    o_resume = '0;
    for (int k = SLOTS; k < NC; k++) begin
      if (keep[k] && (pos[k] == PW'(SLOTS))) o_resume = IDXW'(k - SLOTS);
    end
  end
endmodule

// File: rtl/fc_out_reg.sv
// Single registered stage with valid/ready on both sides.
module fc_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) q <= d;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));

  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/fc_collapser.sv
module fc_collapser
  import fc_pkg::*;
#(
  parameter int unsigned SLOTS = FC_SLOTS,
  parameter int unsigned IW    = FC_IW,
  parameter int unsigned TIDW  = FC_TIDW,
  localparam int unsigned IDXW = $clog2(SLOTS),
  localparam int unsigned CNTW = fc_cnt_w(SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [SLOTS-1:0][IW-1:0] a_insn,
  input  logic [SLOTS-1:0]         a_vld,
  input  logic [SLOTS-1:0]         a_taken,
  input  logic [SLOTS-1:0][IW-1:0] b_insn,
  input  logic [SLOTS-1:0]         b_vld,
  input  logic [SLOTS-1:0]         b_taken,
  input  logic [IDXW-1:0]          b_start,
  input  logic [TIDW-1:0]          in_tid,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [SLOTS-1:0][IW-1:0] out_insn,
  output logic [SLOTS-1:0]         out_vld,
  output logic [SLOTS-1:0]         out_taken,
  output logic [CNTW-1:0]          out_count,
  output logic                     out_trunc,
  output logic [IDXW-1:0]          out_resume,
  output logic [TIDW-1:0]          out_tid
);
  localparam int unsigned DW = SLOTS * IW + 2 * SLOTS + CNTW + 1 + IDXW + TIDW;

  logic [SLOTS-1:0] keep_a, keep_b;

  fc_path_mask #(.SLOTS(SLOTS)) i_mask_a (
    .vld(a_vld), .tk(a_taken), .start('0), .keep(keep_a)
  );
  fc_path_mask #(.SLOTS(SLOTS)) i_mask_b (
    .vld(b_vld), .tk(b_taken), .start(b_start), .keep(keep_b)
  );

  logic [SLOTS-1:0][IW-1:0] p_insn;
  logic [SLOTS-1:0]         p_vld, p_tk;
  logic [CNTW-1:0]          p_count;
  logic                     p_trunc;
  logic [IDXW-1:0]          p_resume;

  fc_pack #(.SLOTS(SLOTS), .IW(IW)) i_pack (
    .cand_insn({b_insn, a_insn}),
    .cand_tk  ({b_taken, a_taken}),
    .keep     ({keep_b, keep_a}),
    .o_insn   (p_insn),
    .o_vld    (p_vld),
    .o_tk     (p_tk),
    .o_count  (p_count),
    .o_trunc  (p_trunc),
    .o_resume (p_resume)
  );

  logic [DW-1:0] stage_d, stage_q;
  assign stage_d = {p_insn, p_vld, p_tk, p_count, p_trunc, p_resume, in_tid};

  fc_out_reg #(.W(DW)) i_oreg (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .d(stage_d),
    .out_valid(out_valid), .out_ready(out_ready), .q(stage_q)
  );

  assign {out_insn, out_vld, out_taken, out_count, out_trunc, out_resume, out_tid} = stage_q;

  // each line keeps at most one taken slot once cut
  p_one_cut_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(keep_a & a_taken));
  p_one_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0(keep_b & b_taken));
  // below the start offset nothing survives
  p_below_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ((keep_b & ((SLOTS'(1) << b_start) - SLOTS'(1))) == '0));
  p_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_vld & (out_vld + SLOTS'(1))) == '0));
  p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_vld) == int'(out_count)));
  p_trunc_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_trunc) |-> (out_count == CNTW'(SLOTS)));
  p_empty_tk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_taken & ~out_vld) == '0));
endmodule

// File: tb/test_fc_collapser.sv
module test_fc_collapser;
  localparam int S = 8;
  localparam int IW = 32;
  localparam int TIDW = 2;
  localparam int IDXW = 3;
  localparam int CNTW = 4;

  typedef struct packed {
    logic [S-1:0][IW-1:0] a_insn;
    logic [S-1:0]         a_vld, a_tk;
    logic [S-1:0][IW-1:0] b_insn;
    logic [S-1:0]         b_vld, b_tk;
    logic [IDXW-1:0]      b_start;
    logic [TIDW-1:0]      tid;
  } stim_t;

  typedef struct packed {
    logic [S-1:0][IW-1:0] insn;
    logic [S-1:0]         vld, tk;
    logic [CNTW-1:0]      cnt;
    logic                 trunc;
    logic [IDXW-1:0]      resume;
    logic [TIDW-1:0]      tid;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  stim_t cur = '0;
  logic [S-1:0][IW-1:0] out_insn;
  logic [S-1:0] out_vld, out_taken;
  logic [CNTW-1:0] out_count;
  logic out_trunc;
  logic [IDXW-1:0] out_resume;
  logic [TIDW-1:0] out_tid;

  int n_checks = 0, n_fail = 0;
  exp_t expq[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  fc_collapser i_fc_collapser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_insn(cur.a_insn), .a_vld(cur.a_vld), .a_taken(cur.a_tk),
    .b_insn(cur.b_insn), .b_vld(cur.b_vld), .b_taken(cur.b_tk),
    .b_start(cur.b_start), .in_tid(cur.tid),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_vld(out_vld), .out_taken(out_taken), .out_count(out_count),
    .out_trunc(out_trunc), .out_resume(out_resume), .out_tid(out_tid)
  );

  function automatic exp_t model(input stim_t s);
    exp_t e;
    logic [2*S-1:0] keep;
    logic [2*S-1:0][IW-1:0] ci;
    logic [2*S-1:0] ct;
    bit seen;
    int n;
    e = '0; keep = '0;
    ci = {s.b_insn, s.a_insn};
    ct = {s.b_tk, s.a_tk};
    seen = 0;
    for (int i = 0; i < S; i++)
      if (s.a_vld[i] && !seen) begin keep[i] = 1; if (s.a_tk[i]) seen = 1; end
    seen = 0;
    for (int i = 0; i < S; i++)
      if (s.b_vld[i] && i >= int'(s.b_start) && !seen) begin
        keep[S+i] = 1; if (s.b_tk[i]) seen = 1;
      end
    n = 0;
    for (int k = 0; k < 2*S; k++) begin
      if (keep[k]) begin
        if (n < S) begin e.insn[n] = ci[k]; e.tk[n] = ct[k]; e.vld[n] = 1; end
        else if (n == S) begin e.trunc = 1; e.resume = IDXW'(k - S); end
        n++;
      end
    end
    e.cnt = CNTW'((n > S) ? S : n);
    e.tid = s.tid;
    return e;
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string expd);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", what, act, expd);
    end
  endtask

  task automatic service();
    exp_t e;
    check(in_ready == (!out_valid || out_ready), "R7 in_ready rule",
          $sformatf("%0b", in_ready), $sformatf("%0b", !out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(0, "R7 unexpected output group", "1", "0");
      end else begin
        e = expq.pop_front();
        check(out_vld == e.vld && out_insn == e.insn, "R1 R2 R3 R4 path and packing",
              $sformatf("vld=%b insn=%h", out_vld, out_insn),
              $sformatf("vld=%b insn=%h", e.vld, e.insn));
        check(out_count == e.cnt, "R4 count",
              $sformatf("%0d", out_count), $sformatf("%0d", e.cnt));
        check(out_trunc == e.trunc && out_resume == e.resume, "R5 trunc/resume",
              $sformatf("%0b/%0d", out_trunc, out_resume),
              $sformatf("%0b/%0d", e.trunc, e.resume));
        check(out_tid == e.tid && out_taken == e.tk, "R6 tid/taken",
              $sformatf("%0d/%b", out_tid, out_taken),
              $sformatf("%0d/%b", e.tid, e.tk));
      end
    end
    if (in_valid && in_ready) expq.push_back(model(cur));
  endtask

  task automatic send(input stim_t s, input int rdy_pct);
    bit acc;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      cur = s; in_valid = 1;
      out_ready = (($urandom % 100) < rdy_pct);
      #1;
      acc = in_ready;
      service();
    end
    @(negedge clk);
    in_valid = 0;
    out_ready = (($urandom % 100) < rdy_pct);
    #1;
    service();
  endtask

  function automatic stim_t base(input int salt);
    stim_t s;
    s = '0;
    for (int i = 0; i < S; i++) begin
      s.a_insn[i] = IW'(32'hA000_0000 + salt * 256 + i);
      s.b_insn[i] = IW'(32'hB000_0000 + salt * 256 + i);
    end
    s.a_vld = '1; s.b_vld = '1;
    return s;
  endfunction

  function automatic logic [S-1:0] rnd_tk();
    logic [S-1:0] t;
    for (int i = 0; i < S; i++) t[i] = (($urandom % 8) == 0);
    return t;
  endfunction

  initial begin
    stim_t s;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(out_valid == 0 && in_ready == 1, "R8 reset state",
          $sformatf("%0b/%0b", out_valid, in_ready), "0/1");

    // R1 R5: sixteen survivors, no taken -> A emitted, resume at B0
    s = base(1); send(s, 100);
    // R1 R3: A cut at 2, B from 5 cut at 6 -> 5 slots
    s = base(2); s.a_tk[2] = 1; s.b_start = 5; s.b_tk[6] = 1; send(s, 100);
    // R4: nothing valid -> empty group
    s = base(3); s.a_vld = '0; s.b_vld = '0; s.tid = 2'd3; send(s, 100);
    // R5: nine survivors -> resume at B7
    s = base(4); s.a_tk[7] = 1; s.b_start = 7; send(s, 100);
    // R1 R4: holes in A, B cut at its start slot
    s = base(5); s.a_vld = 8'b1010_1010; s.b_start = 3; s.b_tk[3] = 1; send(s, 100);
    // R2 R3: taken flag below b_start must not cut line B
    s = base(6); s.a_tk[0] = 1; s.b_tk[1] = 1; s.b_start = 4; s.tid = 2'd1; send(s, 100);
    // R3: exactly eight survivors, no truncation
    s = base(7); s.a_tk[3] = 1; s.b_start = 4; send(s, 100);
    // R7: back-to-back under heavy stalls
    for (int t = 0; t < 300; t++) begin
      s = '0;
      for (int i = 0; i < S; i++) begin
        s.a_insn[i] = IW'($urandom);
        s.b_insn[i] = IW'($urandom);
      end
      s.a_vld = (($urandom % 4) == 0) ? S'($urandom) : '1;
      s.b_vld = (($urandom % 4) == 0) ? S'($urandom) : '1;
      s.a_tk = rnd_tk(); s.b_tk = rnd_tk();
      s.b_start = IDXW'($urandom);
      s.tid = TIDW'($urandom);
      send(s, (t < 150) ? 50 : 90);
    end
    // drain
    in_valid = 0;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk); out_ready = 1; #1; service();
    end
    check(expq.size() == 0, "R7 all groups delivered",
          $sformatf("%0d", expq.size()), "0");
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule